// File: doc/BRIEF.md
# Double-Buffered Gamma Lookup Table

This block applies gamma correction to each pixel of a display stream. It holds two banks of lookup tables. Each table entry packs a red, a green and a blue output value. At any moment one bank corrects pixels and the other bank is open to the host, so a full replacement table can be loaded while correction keeps running. When the new table is complete, the host sets a request bit. At the next frame-start strobe the two banks trade roles, and the request bit clears itself. The host learns that the swap has finished by polling a bank-index status bit until its value changes.

Each colour component of an incoming pixel addresses the table by its own value and takes its own field of the entry it selects. The component width is a parameter: 10 bits gives 1024 entries per bank, and 8 bits gives 256 entries per bank. A table-enable bit chooses between the lookup result and the unmodified pixel. Both paths have the same two-cycle latency, so the valid flag stays aligned with the data in either case.

Top module: `gamma_lut_top`

## Requirements
- R1: After synchronous reset the control register reads 0 (table disabled, no request pending, bank index 0), and `pix_valid_o` is 0.
- R2: Table words and pixels share one packing, with W as the component width. Red sits in bits [3W-1:2W], green in [2W-1:W] and blue in [W-1:0].
- R3: While the table is enabled, each output component equals that component's field of the entry in the active bank at the index given by the same input component. The result appears two cycles after the input, and `pix_valid_o` follows `pix_valid_i` with the same two-cycle delay.
- R4: While the table is disabled, the pixel appears unchanged two cycles after it enters.
- R5: Host table writes always go to the inactive bank and never change the output of the active bank.
- R6: Writing the control register with bit 1 set marks a swap as pending. On the next frame-start strobe the bank index toggles and the pending flag clears on the same edge. A request written in the strobe cycle itself waits for the following strobe.
- R7: The bank index never changes except on a frame-start strobe while a swap is pending.
- R8: Several requests made before one strobe merge into a single swap.
- R9: Host reads return data one cycle after `host_re`. Address 0 returns the control register: bit 0 is enable, bit 1 is the pending flag, bit 2 is the active bank index. An address with its top bit set returns the entry at the low-bit index in the inactive bank.
- R10: Writing the control register with bit 1 clear does not cancel a pending swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | COMP_W+1 | Top bit set selects a table entry; otherwise 0 selects the control register |
| host_wdata | input | 3*COMP_W | Host write data |
| host_rdata | output | 3*COMP_W | Host read data, valid one cycle after `host_re` |
| frame_start | input | 1 | One-cycle strobe at each frame boundary |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_data_i | input | 3*COMP_W | Input pixel, packed red/green/blue |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_data_o | output | 3*COMP_W | Corrected or bypassed pixel |

## Verification
The assertions assume four things about the inputs:
- `frame_start` is a single-cycle strobe.
- The latency checks start counting only once two clean cycles have passed after reset.
- The checker treats a control write with bit 1 set in a strobe cycle as a fresh request, not as a failure to clear.
- Signal values sampled during reset are never relied on.

The stimulus drives every input on the falling edge and keeps each strobe one cycle wide. It streams pixels only after reset is released. It raises requests both well before a strobe and in pairs, so the merge and hold paths are exercised without any read and write to the same entry colliding in one cycle.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_REQ_BIT  = 1;
  localparam int CTRL_BANK_BIT = 2;
  localparam int CTRL_BITS     = 3;
endpackage

// File: rtl/gamma_bank_ctrl.sv
module gamma_bank_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_we,
  input  logic wr_en_bit,
  input  logic wr_req_bit,
  input  logic frame_start,
  output logic lut_en,
  output logic swap_pending,
  output logic active_bank
);
  logic do_swap;
  assign do_swap = frame_start & swap_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      lut_en       <= 1'b0;
      swap_pending <= 1'b0;
      active_bank  <= 1'b0;
    end else begin
      if (ctrl_we) lut_en <= wr_en_bit;
      if (do_swap) active_bank <= ~active_bank;
      // merge: a new request only sets, a swap only clears the old one
      swap_pending <= (swap_pending & ~do_swap) | (ctrl_we & wr_req_bit);
    end
  end
endmodule

// File: rtl/gamma_lane.sv
module gamma_lane #(
  parameter int COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [COMP_W:0]   wr_addr,
  input  logic [COMP_W-1:0] wr_data,
  input  logic              hrd_en,
  input  logic [COMP_W:0]   hrd_addr,
  output logic [COMP_W-1:0] hrd_data,
  input  logic              px_bank,
  input  logic              px_en,
  input  logic [COMP_W-1:0] px_in,
  output logic [COMP_W-1:0] px_out
);
  localparam int DEPTH = 2 * (1 << COMP_W);

  logic [COMP_W-1:0] mem [DEPTH];
  logic [COMP_W-1:0] lut_q;
  logic [COMP_W-1:0] byp_q;
  logic              en_q;

  // host port: write and read, no reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (hrd_en) hrd_data <= mem[hrd_addr];
  end

  // pixel port: registered read
  always_ff @(posedge clk) begin
    lut_q <= mem[{px_bank, px_in}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q  <= '0;
      en_q   <= 1'b0;
      px_out <= '0;
    end else begin
      byp_q  <= px_in;
      en_q   <= px_en;
      px_out <= en_q ? lut_q : byp_q;
    end
  end
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top #(
  parameter int COMP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_we,
  input  logic                  host_re,
  input  logic [COMP_W:0]       host_addr,
  input  logic [3*COMP_W-1:0]   host_wdata,
  output logic [3*COMP_W-1:0]   host_rdata,
  input  logic                  frame_start,
  input  logic                  pix_valid_i,
  input  logic [3*COMP_W-1:0]   pix_data_i,
  output logic                  pix_valid_o,
  output logic [3*COMP_W-1:0]   pix_data_o
);
  import gamma_lut_pkg::*;

  localparam int DATA_W = 3 * COMP_W;
  localparam int LANES  = 3;

  logic is_tab, is_ctrl, tab_we, ctrl_we;
  logic lut_en, swap_pending, active_bank;
  logic [COMP_W:0] tab_addr;
  logic [DATA_W-1:0] lane_rd;
  logic rd_tab_q;
  logic [DATA_W-1:0] ctrl_q;
  logic v1_q;

  assign is_tab   = host_addr[COMP_W];
  assign is_ctrl  = ~host_addr[COMP_W] && (host_addr[COMP_W-1:0] == '0);
  assign tab_we   = host_we & is_tab;
  assign ctrl_we  = host_we & is_ctrl;
  assign tab_addr = {~active_bank, host_addr[COMP_W-1:0]};

  gamma_bank_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .ctrl_we      (ctrl_we),
    .wr_en_bit    (host_wdata[CTRL_EN_BIT]),
    .wr_req_bit   (host_wdata[CTRL_REQ_BIT]),
    .frame_start  (frame_start),
    .lut_en       (lut_en),
    .swap_pending (swap_pending),
    .active_bank  (active_bank)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    gamma_lane #(.COMP_W(COMP_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (tab_we),
      .wr_addr  (tab_addr),
      .wr_data  (host_wdata[k*COMP_W +: COMP_W]),
      .hrd_en   (host_re & is_tab),
      .hrd_addr (tab_addr),
      .hrd_data (lane_rd[k*COMP_W +: COMP_W]),
      .px_bank  (active_bank),
      .px_en    (lut_en),
      .px_in    (pix_data_i[k*COMP_W +: COMP_W]),
      .px_out   (pix_data_o[k*COMP_W +: COMP_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_tab_q    <= 1'b0;
      ctrl_q      <= '0;
      v1_q        <= 1'b0;
      pix_valid_o <= 1'b0;
    end else begin
      v1_q        <= pix_valid_i;
      pix_valid_o <= v1_q;
      if (host_re) begin
        rd_tab_q <= is_tab;
        ctrl_q   <= '0;
        if (is_ctrl) begin
          ctrl_q[CTRL_EN_BIT]   <= lut_en;
          ctrl_q[CTRL_REQ_BIT]  <= swap_pending;
          ctrl_q[CTRL_BANK_BIT] <= active_bank;
        end
      end
    end
  end

  assign host_rdata = rd_tab_q ? lane_rd : ctrl_q;
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
  parameter int COMP_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                frame_start,
  input logic                host_we,
  input logic [COMP_W:0]     host_addr,
  input logic [3*COMP_W-1:0] host_wdata,
  input logic                pix_valid_i,
  input logic [3*COMP_W-1:0] pix_data_i,
  input logic                pix_valid_o,
  input logic [3*COMP_W-1:0] pix_data_o,
  input logic                lut_en,
  input logic                swap_pending,
  input logic                active_bank
);
  logic [1:0] up_cnt;
  logic       req_wr;

  assign req_wr = host_we && (host_addr == '0) && host_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) up_cnt <= '0;
    else if (up_cnt != 2'd2) up_cnt <= up_cnt + 2'd1;
  end

  p_swap_at_frame_r6: assert property (@(posedge clk) disable iff (rst)
    (swap_pending && frame_start) |=> (active_bank != $past(active_bank)));

  p_pending_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (swap_pending && frame_start && !req_wr) |=> !swap_pending);

  p_bank_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(swap_pending && frame_start) |=> $stable(active_bank));

  p_req_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (swap_pending && !frame_start) |=> swap_pending);

  p_valid_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (up_cnt == 2'd2) |-> (pix_valid_o == $past(pix_valid_i, 2)));

  p_bypass_r4: assert property (@(posedge clk) disable iff (rst)
    (up_cnt == 2'd2 && $past(pix_valid_i, 2) && !$past(lut_en, 2))
      |-> (pix_data_o == $past(pix_data_i, 2)));
endmodule

bind gamma_lut_top gamma_lut_chk #(.COMP_W(COMP_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .frame_start  (frame_start),
  .host_we      (host_we),
  .host_addr    (host_addr),
  .host_wdata   (host_wdata),
  .pix_valid_i  (pix_valid_i),
  .pix_data_i   (pix_data_i),
  .pix_valid_o  (pix_valid_o),
  .pix_data_o   (pix_data_o),
  .lut_en       (lut_en),
  .swap_pending (swap_pending),
  .active_bank  (active_bank)
);

// File: tb/gamma_lut_top_tb.sv
module gamma_lut_top_tb;
  localparam int W = 8;
  localparam int D = 3 * W;
  localparam int N = 1 << W;
  localparam int M = N - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 1'b0, host_re = 1'b0;
  logic [W:0] host_addr = '0;
  logic [D-1:0] host_wdata = '0;
  logic [D-1:0] host_rdata;
  logic frame_start = 1'b0;
  logic pix_valid_i = 1'b0;
  logic [D-1:0] pix_data_i = '0;
  logic pix_valid_o;
  logic [D-1:0] pix_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gamma_lut_top #(.COMP_W(W)) u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .frame_start(frame_start), .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i),
    .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o)
  );

  function automatic logic [D-1:0] ent(int i, int s);
    logic [W-1:0] r, g, b;
    r = W'((i * 5 + s * 37) & M);
    g = W'((i ^ (s * 91)) & M);
    b = W'((M - i + s) & M);
    return {r, g, b};
  endfunction

  function automatic logic [D-1:0] lookup(logic [D-1:0] px, int s);
    logic [D-1:0] er, eg, eb;
    er = ent(int'(px[3*W-1:2*W]), s);
    eg = ent(int'(px[2*W-1:W]), s);
    eb = ent(int'(px[W-1:0]), s);
    return {er[3*W-1:2*W], eg[2*W-1:W], eb[W-1:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [W:0] a, logic [D-1:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(logic [W:0] a, output logic [D-1:0] d);
    @(negedge clk);
    host_re = 1'b1; host_addr = a;
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  task automatic strobe();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic pix(logic [D-1:0] px, logic [D-1:0] exp, string req);
    @(negedge clk);
    pix_valid_i = 1'b1; pix_data_i = px;
    @(negedge clk);
    pix_valid_i = 1'b0;
    @(negedge clk);
    chk(req, 32'(pix_valid_o), 32'd1);
    chk(req, 32'(pix_data_o), 32'(exp));
  endtask

  task automatic load(int s);
    for (int i = 0; i < N; i++) wr({1'b1, W'(i)}, ent(i, s));
  endtask

  task automatic t_reset();
    logic [D-1:0] d;
    chk("R1 valid", 32'(pix_valid_o), 32'd0);
    rd('0, d);
    chk("R1 ctrl", 32'(d), 32'd0);
  endtask

  task automatic t_bypass();
    pix(24'h123456, 24'h123456, "R4 bypass");
    pix(24'hFF00A5, 24'hFF00A5, "R4 bypass");
    @(negedge clk);
    chk("R3 valid drop", 32'(pix_valid_o), 32'd0);
  endtask

  task automatic t_first_swap();
    logic [D-1:0] d;
    load(1);
    rd({1'b1, 8'd0}, d);   chk("R9 tab 0", 32'(d), 32'(ent(0, 1)));
    rd({1'b1, 8'd255}, d); chk("R9 tab 255", 32'(d), 32'(ent(255, 1)));
    rd({1'b1, 8'd77}, d);  chk("R9 tab 77", 32'(d), 32'(ent(77, 1)));
    wr('0, 24'h000002);
    wr('0, 24'h000000);
    rd('0, d); chk("R10 pending kept", 32'(d), 32'h2);
    repeat (5) @(negedge clk);
    rd('0, d); chk("R7 no swap", 32'(d), 32'h2);
    strobe();
    rd('0, d); chk("R6 swapped", 32'(d), 32'h4);
  endtask

  task automatic t_lookup();
    logic [D-1:0] d;
    wr('0, 24'h000001);
    rd('0, d); chk("R9 ctrl en", 32'(d), 32'h5);
    pix(24'h000000, lookup(24'h000000, 1), "R3 zero");
    pix(24'hFFFFFF, lookup(24'hFFFFFF, 1), "R3 max");
    pix(24'h10A0F3, lookup(24'h10A0F3, 1), "R2 R3 mixed");
    pix(24'h7F8001, lookup(24'h7F8001, 1), "R2 R3 mixed");
  endtask

  task automatic t_hidden_load();
    logic [D-1:0] d;
    load(2);
    pix(24'h10A0F3, lookup(24'h10A0F3, 1), "R5 active intact");
    rd({1'b1, 8'd200}, d); chk("R9 R5 inactive", 32'(d), 32'(ent(200, 2)));
  endtask

  task automatic t_merge();
    logic [D-1:0] d;
    wr('0, 24'h000003);
    wr('0, 24'h000003);
    strobe();
    rd('0, d); chk("R8 one swap", 32'(d), 32'h1);
    strobe();
    rd('0, d); chk("R8 no second", 32'(d), 32'h1);
    pix(24'h10A0F3, lookup(24'h10A0F3, 2), "R3 new table");
    pix(24'h00FF80, lookup(24'h00FF80, 2), "R3 new table");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bypass();
    t_first_swap();
    t_lookup();
    t_hidden_load();
    t_merge();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule